// File: doc/BRIEF.md
# Per-Channel Ramped Logarithmic Attenuator

This block scales a time-multiplexed stream of 24-bit signed audio samples. Eight channels share one datapath, and each channel has its own 8-bit attenuation code and its own mute bit. The attenuation is logarithmic, at 0.375 dB per code step, so the 255 non-zero codes span roughly 95 dB. Code 0 is unity gain.

Settings do not take effect at once. Each channel keeps an applied code. Every time a sample of that channel passes through, the applied code moves one step toward the channel's target. The target is the programmed code, or the largest code while the channel is muted. Once a muted channel has reached the largest code, its output is forced to exactly zero. Gain changes and mutes therefore settle gradually, and a sudden gain jump cannot produce a click.

The gain is a 16-entry mantissa, which covers one 6 dB octave, followed by an arithmetic right shift of one bit per octave. The product is rounded and saturated. A result leaves the block two cycles after its input strobe and carries the same channel index.

Top module: `vra_atten_top`

## Requirements
- R1: After reset every applied code is 0 and out_valid is low. The first sample of any channel then passes through unchanged.
- R2: A sample x processed with applied code c gives floor((x*M[c mod 16] + 2^(s-1)) / 2^s), where s = 15 + floor(c/16). M is 32768, 31383, 30057, 28787, 27571, 26406, 25290, 24221, 23198, 22218, 21279, 20380, 19519, 18694, 17904, 17148 for indices 0 to 15. The result is saturated to the signed 24-bit range.
- R3: Every in_valid cycle produces exactly one out_valid cycle two clock cycles later, with out_ch equal to the in_ch of that strobe. No other cycle asserts out_valid.
- R4: A sample of channel k uses that channel's applied code as it stood before the sample. The applied code then moves by exactly one toward the target.
- R5: A channel's applied code changes only on samples of that channel. Setting changes on a channel that sends no samples leave its next output at the old code.
- R6: When the applied code equals the target, samples leave the code unchanged.
- R7: While a channel's mute bit is set, its target is 255. A sample processed with applied code 255 and mute set gives exactly 0. Samples processed during the ramp still give the attenuated value.
- R8: When the mute bit is cleared, the applied code ramps back one step per sample to the programmed code. The first sample after the mute is cleared gives the code-255 value, not zero.
- R9: At the extremes, code 0 passes the full-scale values -8388608 and 8388607 unchanged. Code 255 gives 134 for input 8388607.
- R10: Strobes on consecutive cycles are all accepted. Their results appear on consecutive cycles in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | 3 | Channel index of the input sample |
| in_sample | input | 24 | Signed input sample |
| vol_codes | input | 64 | Eight attenuation codes; channel k in bits [8k+7:8k] |
| mute_mask | input | 8 | Mute bit per channel; bit k for channel k |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | 3 | Channel index of the output sample |
| out_sample | output | 24 | Signed attenuated sample |

## Verification
The hardest states to reach are the two ends of a full mute ramp: the exact sample at which the applied code reaches 255 and the output turns to zero, and the first sample after unmute, which must still be non-zero. The ramp advances only on samples of its own channel, so the stimulus drives that channel through more than 255 samples and tracks the applied code in a bench model, checking every intermediate output along the way. The same per-sample stepping is used to preload seven different codes, including 255, before the table walk, so that every mantissa boundary and both shift extremes are covered.

// File: rtl/vra_pkg.sv
package vra_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int CODE_W     = 8;
    localparam int NUM_CH     = 8;
    localparam int MANT_IDX_W = 4;
    localparam int MANT_W     = 16;
    localparam int BASE_SHIFT = 15;

    // Gain mantissa for one octave, in units of 2^-15 at 0.375 dB per entry
    function automatic logic [MANT_W-1:0] vra_mant(input logic [MANT_IDX_W-1:0] idx);
        logic [MANT_W-1:0] m;
        case (idx)
            4'd0:    m = 16'd32768;
            4'd1:    m = 16'd31383;
            4'd2:    m = 16'd30057;
            4'd3:    m = 16'd28787;
            4'd4:    m = 16'd27571;
            4'd5:    m = 16'd26406;
            4'd6:    m = 16'd25290;
            4'd7:    m = 16'd24221;
            4'd8:    m = 16'd23198;
            4'd9:    m = 16'd22218;
            4'd10:   m = 16'd21279;
            4'd11:   m = 16'd20380;
            4'd12:   m = 16'd19519;
            4'd13:   m = 16'd18694;
            4'd14:   m = 16'd17904;
            default: m = 16'd17148;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vra_code_step.sv
module vra_code_step #(
    parameter int CW = vra_pkg::CODE_W
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] tgt,
    output logic [CW-1:0] nxt
);

    always_comb begin
        if (cur < tgt) begin
            nxt = cur + CW'(1);
        end else if (cur > tgt) begin
            nxt = cur - CW'(1);
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/vra_ramp_ctrl.sv
module vra_ramp_ctrl #(
    parameter int NCH = vra_pkg::NUM_CH,
    parameter int DW  = vra_pkg::SAMPLE_W,
    parameter int CW  = vra_pkg::CODE_W,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHW-1:0]    in_ch,
    input  logic [DW-1:0]     in_sample,
    input  logic [NCH*CW-1:0] vol_codes,
    input  logic [NCH-1:0]    mute_mask,
    output logic              s1_valid,
    output logic [CHW-1:0]    s1_ch,
    output logic [DW-1:0]     s1_sample,
    output logic [CW-1:0]     s1_code,
    output logic              s1_zero
);

    localparam logic [CW-1:0] CODE_MAX = '1;

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cur;
        logic                   vld;
        logic [CHW-1:0]         ch;
        logic [DW-1:0]          smp;
        logic [CW-1:0]          code;
        logic                   zero;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic [NCH-1:0][CW-1:0] tgt;
    logic [NCH-1:0][CW-1:0] nxt;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign tgt[i] = mute_mask[i] ? CODE_MAX : vol_codes[i*CW +: CW];

        vra_code_step #(.CW(CW)) u_step (
            .cur (st_q.cur[i]),
            .tgt (tgt[i]),
            .nxt (nxt[i])
        );

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cur[i] != $past(st_q.cur[i])) |->
            ((st_q.cur[i] == $past(st_q.cur[i]) + CW'(1)) ||
             (st_q.cur[i] == $past(st_q.cur[i]) - CW'(1)))); // R4

        AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid && (32'(in_ch) == i)) |=> $stable(st_q.cur[i])); // R5

        AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (32'(in_ch) == i) && (st_q.cur[i] == tgt[i]))
            |=> $stable(st_q.cur[i])); // R6
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid && (32'(in_ch) < NCH)) begin
            st_d.ch          = in_ch;
            st_d.smp         = in_sample;
            st_d.code        = st_q.cur[in_ch];
            st_d.zero        = mute_mask[in_ch] && (st_q.cur[in_ch] == CODE_MAX);
            st_d.cur[in_ch]  = nxt[in_ch];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid  = st_q.vld;
    assign s1_ch     = st_q.ch;
    assign s1_sample = st_q.smp;
    assign s1_code   = st_q.code;
    assign s1_zero   = st_q.zero;

endmodule

// File: rtl/vra_gain_mult.sv
module vra_gain_mult #(
    parameter int DW  = vra_pkg::SAMPLE_W,
    parameter int CW  = vra_pkg::CODE_W,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s1_valid,
    input  logic [CHW-1:0] s1_ch,
    input  logic [DW-1:0]  s1_sample,
    input  logic [CW-1:0]  s1_code,
    input  logic           s1_zero,
    output logic           out_valid,
    output logic [CHW-1:0] out_ch,
    output logic [DW-1:0]  out_sample
);

    localparam int FW        = vra_pkg::MANT_IDX_W;
    localparam int MW        = vra_pkg::MANT_W;
    localparam int OCT_W     = CW - FW;
    localparam int MAX_SHIFT = vra_pkg::BASE_SHIFT + (2**OCT_W) - 1;
    localparam int SHW       = $clog2(MAX_SHIFT + 1);
    localparam int PW        = DW + MW + 1;
    localparam int AW        = PW + 1;
    localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    typedef struct packed {
        logic           vld;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  smp;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [MW-1:0]          mant;
    logic [SHW-1:0]         shamt;
    logic signed [PW-1:0]   prod;
    logic signed [AW-1:0]   half;
    logic signed [AW-1:0]   acc;
    logic signed [AW-1:0]   shd;
    logic [DW-1:0]          sat;

    always_comb begin
        mant  = vra_pkg::vra_mant(s1_code[FW-1:0]);
        shamt = SHW'(vra_pkg::BASE_SHIFT) + SHW'(s1_code[CW-1:FW]);
        prod  = $signed(s1_sample) * $signed({1'b0, mant});
        half  = AW'(1) << (shamt - SHW'(1));
        acc   = {prod[PW-1], prod} + half;
        shd   = acc >>> shamt;
        if (shd > MAXV) begin
            sat = MAXV[DW-1:0];
        end else if (shd < MINV) begin
            sat = MINV[DW-1:0];
        end else begin
            sat = shd[DW-1:0];
        end

        st_d     = st_q;
        st_d.vld = s1_valid;
        if (s1_valid) begin
            st_d.ch  = s1_ch;
            st_d.smp = s1_zero ? '0 : sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_ch     = st_q.ch;
    assign out_sample = st_q.smp;

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_zero) |=> (out_valid && (out_sample == '0))); // R7

    AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_zero && (s1_code == '0)) |=> (out_sample == $past(s1_sample))); // R9

endmodule

// File: rtl/vra_atten_top.sv
module vra_atten_top #(
    parameter int NCH = vra_pkg::NUM_CH,
    parameter int DW  = vra_pkg::SAMPLE_W,
    parameter int CW  = vra_pkg::CODE_W,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHW-1:0]    in_ch,
    input  logic [DW-1:0]     in_sample,
    input  logic [NCH*CW-1:0] vol_codes,
    input  logic [NCH-1:0]    mute_mask,
    output logic              out_valid,
    output logic [CHW-1:0]    out_ch,
    output logic [DW-1:0]     out_sample
);

    logic           s1_valid;
    logic [CHW-1:0] s1_ch;
    logic [DW-1:0]  s1_sample;
    logic [CW-1:0]  s1_code;
    logic           s1_zero;

    vra_ramp_ctrl #(.NCH(NCH), .DW(DW), .CW(CW)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ch     (in_ch),
        .in_sample (in_sample),
        .vol_codes (vol_codes),
        .mute_mask (mute_mask),
        .s1_valid  (s1_valid),
        .s1_ch     (s1_ch),
        .s1_sample (s1_sample),
        .s1_code   (s1_code),
        .s1_zero   (s1_zero)
    );

    vra_gain_mult #(.DW(DW), .CW(CW), .CHW(CHW)) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_ch      (s1_ch),
        .s1_sample  (s1_sample),
        .s1_code    (s1_code),
        .s1_zero    (s1_zero),
        .out_valid  (out_valid),
        .out_ch     (out_ch),
        .out_sample (out_sample)
    );

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_valid && (out_ch == $past(in_ch, 2)))); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R3

endmodule

// File: tb/vra_atten_top_bench.sv
`timescale 1ns/1ps
module vra_atten_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_ch = '0;
    logic [23:0] in_sample = '0;
    logic [63:0] vol_codes = '0;
    logic [7:0]  mute_mask = '0;
    logic        out_valid;
    logic [2:0]  out_ch;
    logic [23:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int mcur [8];
    int vset [8];
    bit mset [8];

    localparam int MANT [16] = '{32768, 31383, 30057, 28787, 27571, 26406, 25290, 24221,
                                 23198, 22218, 21279, 20380, 19519, 18694, 17904, 17148};

    // channel (3 bits) and sample (24 bits)
    localparam logic [26:0] TAB [12] = '{
        {3'd0, 24'h123456}, {3'd1, 24'h7FFFFF}, {3'd2, 24'h800000}, {3'd3, 24'h400001},
        {3'd4, 24'hFFFFFF}, {3'd5, 24'h7FFFFF}, {3'd6, 24'h7FFFFF}, {3'd7, 24'h7FFFFF},
        {3'd1, 24'hC00003}, {3'd3, 24'h000001}, {3'd4, 24'h000011}, {3'd2, 24'h3FFFFF}
    };

    always #2.5 clk = ~clk;

    vra_atten_top u_vra_atten_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ch      (in_ch),
        .in_sample  (in_sample),
        .vol_codes  (vol_codes),
        .mute_mask  (mute_mask),
        .out_valid  (out_valid),
        .out_ch     (out_ch),
        .out_sample (out_sample)
    );

    function automatic logic [23:0] ref_gain(input logic [23:0] x, input int code);
        longint xs = longint'($signed(x));
        longint p = xs * longint'(MANT[code % 16]);
        int s = 15 + code / 16;
        longint r = (p + (longint'(1) <<< (s - 1))) >>> s;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r[23:0];
    endfunction

    function automatic logic [23:0] model_step(input int ch, input logic [23:0] x);
        int used = mcur[ch];
        int tgt = mset[ch] ? 255 : vset[ch];
        if (used < tgt) mcur[ch] = used + 1;
        else if (used > tgt) mcur[ch] = used - 1;
        if (mset[ch] && used == 255) return 24'd0;
        return ref_gain(x, used);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_vol(input int ch, input int v);
        vset[ch] = v;
        vol_codes[ch*8 +: 8] = 8'(v);
    endtask

    task automatic set_mute(input int ch, input bit m);
        mset[ch] = m;
        mute_mask[ch] = m;
    endtask

    task automatic send(input int ch, input logic [23:0] x, input string tag);
        logic [23:0] e;
        e = model_step(ch, x);
        @(negedge clk);
        in_valid = 1'b1; in_ch = 3'(ch); in_sample = x;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3", "valid after one cycle", longint'(out_valid), 0);
        @(negedge clk);
        chk("R3", "valid after two cycles", longint'(out_valid), 1);
        chk("R3", "channel", longint'(out_ch), longint'(ch));
        chk(tag, "sample", longint'($signed(out_sample)), longint'($signed(e)));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            mcur[i] = 0; vset[i] = 0; mset[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", longint'(out_valid), 0);
        chk("R1", "out_sample after reset", longint'(out_sample), 0);

        // R1: unity gain on first sample
        send(0, 24'h2468AC, "R1");
        send(0, 24'h800000, "R9");
        send(0, 24'h7FFFFF, "R9");

        // R4: preload codes by ramping one step per sample
        set_vol(1, 1); set_vol(2, 7); set_vol(3, 15); set_vol(4, 16);
        set_vol(5, 100); set_vol(6, 200); set_vol(7, 255);
        for (int ch = 1; ch < 8; ch++) begin
            while (mcur[ch] != vset[ch]) send(ch, 24'h5A5A5A, "R4");
        end

        // R2: gain table walk at settled codes
        for (int k = 0; k < 12; k++) begin
            send(int'(TAB[k][26:24]), TAB[k][23:0], "R2");
        end

        // R9: code 255 extreme
        send(7, 24'h7FFFFF, "R9");
        chk("R9", "code 255 full scale", longint'($signed(out_sample)), 134);

        // R6: holding at target
        send(5, 24'h0F0F0F, "R6");
        send(5, 24'h0F0F0F, "R6");

        // R4: short ramp with code used before the step
        set_vol(1, 5);
        for (int k = 0; k < 6; k++) send(1, 24'h600000, "R4");

        // R5: setting change on an idle channel
        set_vol(0, 60);
        send(2, 24'h111111, "R5");
        send(0, 24'h333333, "R5");
        chk("R5", "idle channel kept code 0", longint'(out_sample), longint'(24'h333333));

        // R7: mute ramp then exact zero
        set_mute(3, 1'b1);
        while (mcur[3] != 255) send(3, 24'h7FFFFF, "R7");
        send(3, 24'h7FFFFF, "R7");
        chk("R7", "muted output zero", longint'(out_sample), 0);
        send(3, 24'h800000, "R7");

        // R8: unmute ramps back
        set_mute(3, 1'b0);
        send(3, 24'h7FFFFF, "R8");
        chk("R8", "first unmuted sample", longint'($signed(out_sample)), 134);
        while (mcur[3] != vset[3]) send(3, 24'h7FFFFF, "R8");
        send(3, 24'h7FFFFF, "R8");

        // R10: back-to-back strobes
        begin
            logic [23:0] e0, e1, e2;
            e0 = model_step(4, 24'h700000);
            e1 = model_step(6, 24'h100000);
            e2 = model_step(0, 24'h7FFFFF);
            @(negedge clk); in_valid = 1'b1; in_ch = 3'd4; in_sample = 24'h700000;
            @(negedge clk); in_ch = 3'd6; in_sample = 24'h100000;
            @(negedge clk); in_ch = 3'd0; in_sample = 24'h7FFFFF;
            chk("R10", "first valid", longint'(out_valid), 1);
            chk("R10", "first channel", longint'(out_ch), 4);
            chk("R10", "first sample", longint'(out_sample), longint'(e0));
            @(negedge clk); in_valid = 1'b0;
            chk("R10", "second channel", longint'(out_ch), 6);
            chk("R10", "second sample", longint'(out_sample), longint'(e1));
            @(negedge clk);
            chk("R10", "third valid", longint'(out_valid), 1);
            chk("R10", "third channel", longint'(out_ch), 0);
            chk("R10", "third sample", longint'(out_sample), longint'(e2));
            @(negedge clk);
            chk("R3", "idle after burst", longint'(out_valid), 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule